// File: doc/BRIEF.md
# Dual-Core Lockstep Divergence Monitor

This block sits beside two identical 32-bit processor cores that execute the same program in lockstep. Each cycle it compares three groups of core activity: register-file write beats, register-file observation beats (a scanned or selected read port), and prefetched instruction beats. Every group has its own sticky error flag. A divergence in any group sets that group's flag and can raise an interrupt request, so that a software handler can start recovery.

At the first divergence the monitor freezes a hardware snapshot. The snapshot holds the last program counter both cores agreed on, the last register write both cores agreed on, and the value of a free-running cycle counter. The handler reads the flags and the snapshot through an APB slave register bank, restores the processor state, and then clears the flags by writing 1 to them. This setup replaces triple redundancy or checkpoint rollback. The cores, the interrupt controller and the handler are outside the block.

Top module: `lockstep_guard`

## Requirements
- R1: Write class: a cycle in which exactly one core asserts its write strobe, or both assert it and the destination index or write data differ, sets status bit 0 on the next clock edge.
- R2: Observation class: a cycle in which exactly one core asserts its observation strobe, or both assert it and the index or data differ, sets status bit 1 on the next clock edge.
- R3: Prefetch class: a cycle in which exactly one core asserts its prefetch strobe, or both assert it and the fetch PC or instruction word differ, sets status bit 2 on the next clock edge.
- R4: No flag is set in a cycle where, for every class, both cores present identical valid beats or neither core asserts the strobe, whatever the payloads are.
- R5: Status bits at address 0x00 are sticky. A write of 1 to a bit clears it, and a write of 0 leaves it unchanged. When a new divergence in a class falls in the same cycle as the clearing write for that class, the bit stays set.
- R6: The irq output is high exactly when bit 0 of the register at 0x04 (global interrupt enable) is 1 and at least one status bit is set. With the enable at 0, flags are still set, so software can poll them.
- R7: When a divergence occurs while no status bit is set, the snapshot captures three things: the PC of the latest agreed prefetch (0x08), the index (0x0C, zero-extended) and data (0x10) of the latest agreed register write, and the cycle count (0x14). An agreement in the same cycle as the divergence counts as the latest. The snapshot does not change while any status bit is set.
- R8: The captured cycle count is the number of clock edges between reset release and the divergence cycle. The first cycle after reset counts as 0.
- R9: APB accesses have no wait states (pready high) and never report an error (pslverr low). Reads of any address other than 0x00, 0x04, 0x08, 0x0C, 0x10 or 0x14 return zero. Writes to the snapshot addresses are ignored.
- R10: After reset, all status bits, the enable, all snapshot fields and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_wr_vld | input | 1 | Core A register write strobe |
| a_wr_idx | input | 5 | Core A write destination index |
| a_wr_data | input | 32 | Core A write data |
| b_wr_vld | input | 1 | Core B register write strobe |
| b_wr_idx | input | 5 | Core B write destination index |
| b_wr_data | input | 32 | Core B write data |
| a_rf_vld | input | 1 | Core A observation strobe |
| a_rf_idx | input | 5 | Core A observed register index |
| a_rf_data | input | 32 | Core A observed register content |
| b_rf_vld | input | 1 | Core B observation strobe |
| b_rf_idx | input | 5 | Core B observed register index |
| b_rf_data | input | 32 | Core B observed register content |
| a_pf_vld | input | 1 | Core A prefetch strobe |
| a_pf_pc | input | 32 | Core A fetch PC |
| a_pf_insn | input | 32 | Core A prefetched instruction |
| b_pf_vld | input | 1 | Core B prefetch strobe |
| b_pf_pc | input | 32 | Core B fetch PC |
| b_pf_insn | input | 32 | Core B prefetched instruction |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error, always low |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can coincide on the status register: a software write that clears a flag, and a hardware divergence that sets the same flag. The bench provokes this by driving a one-sided write strobe in the exact access-phase cycle of a clearing APB write to 0x00. A read afterwards must show the bit still set. The snapshot freeze is judged in the same way: a second divergence in another class, and later the recapture after all flags are cleared, must give exactly the fields and cycle count that the bench predicts from its own edge counter.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    localparam int XLEN   = 32;
    localparam int IDX_W  = 5;
    localparam int ADDR_W = 8;
    localparam int CNT_W  = 32;
    localparam int NCLS   = 3;
    localparam int CMP_W  = 2 * XLEN;

    typedef enum logic [1:0] {
        CLS_WR = 2'd0,
        CLS_RF = 2'd1,
        CLS_PF = 2'd2
    } cls_e;

    localparam logic [ADDR_W-1:0] A_STAT = 8'h00;
    localparam logic [ADDR_W-1:0] A_IEN  = 8'h04;
    localparam logic [ADDR_W-1:0] A_SPC  = 8'h08;
    localparam logic [ADDR_W-1:0] A_SIDX = 8'h0C;
    localparam logic [ADDR_W-1:0] A_SDAT = 8'h10;
    localparam logic [ADDR_W-1:0] A_SCYC = 8'h14;

    typedef struct packed {
        logic [XLEN-1:0]  pc;
        logic [IDX_W-1:0] idx;
        logic [XLEN-1:0]  data;
        logic [CNT_W-1:0] cyc;
    } snap_t;

    function automatic logic [CMP_W-1:0] pack_reg(input logic [IDX_W-1:0] idx,
                                                  input logic [XLEN-1:0]  data);
        return {{(CMP_W-IDX_W-XLEN){1'b0}}, idx, data};
    endfunction

    function automatic logic [CMP_W-1:0] pack_fetch(input logic [XLEN-1:0] pc,
                                                    input logic [XLEN-1:0] insn);
        return {pc, insn};
    endfunction

endpackage

// File: rtl/lsc_cmp.sv
module lsc_cmp #(
    parameter int W = 64
) (
    input  logic         a_vld,
    input  logic         b_vld,
    input  logic [W-1:0] a_pay,
    input  logic [W-1:0] b_pay,
    output logic         miss,
    output logic         agree
);
    logic both;
    logic same;

    always_comb begin
        both  = a_vld & b_vld;
        same  = (a_pay == b_pay);
        miss  = (a_vld ^ b_vld) | (both & ~same);
        agree = both & same;
    end
endmodule

// File: rtl/lsc_snap.sv
module lsc_snap
    import lsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              armed,
    input  logic [NCLS-1:0]   miss,
    input  logic [NCLS-1:0]   agree,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [XLEN-1:0]   wr_data,
    input  logic [XLEN-1:0]   pf_pc,
    output snap_t             snap
);
    logic [CNT_W-1:0] cyc_q;
    logic [XLEN-1:0]  pc_q,   pc_d;
    logic [IDX_W-1:0] idx_q,  idx_d;
    logic [XLEN-1:0]  dat_q,  dat_d;
    logic             capture;

    always_comb begin
        pc_d    = agree[CLS_PF] ? pf_pc   : pc_q;
        idx_d   = agree[CLS_WR] ? wr_idx  : idx_q;
        dat_d   = agree[CLS_WR] ? wr_data : dat_q;
        capture = armed & (|miss);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= '0;
            pc_q  <= '0;
            idx_q <= '0;
            dat_q <= '0;
            snap  <= '0;
        end else begin
            cyc_q <= cyc_q + 1'b1;
            pc_q  <= pc_d;
            idx_q <= idx_d;
            dat_q <= dat_d;
            if (capture) begin
                snap.pc   <= pc_d;
                snap.idx  <= idx_d;
                snap.data <= dat_d;
                snap.cyc  <= cyc_q;
            end
        end
    end
endmodule

// File: rtl/lsc_apb.sv
module lsc_apb
    import lsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [XLEN-1:0]   pwdata,
    output logic [XLEN-1:0]   prdata,
    input  logic [NCLS-1:0]   miss,
    input  snap_t             snap,
    output logic [NCLS-1:0]   flags,
    output logic              ien,
    output logic              irq
);
    logic            wr_en;
    logic [NCLS-1:0] clr;
    logic            unused_wbits;

    assign unused_wbits = ^pwdata[XLEN-1:NCLS];

    always_comb begin
        wr_en = psel & penable & pwrite;
        clr   = (wr_en && paddr == A_STAT) ? pwdata[NCLS-1:0] : '0;
        irq   = ien & (|flags);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            ien   <= 1'b0;
        end else begin
            flags <= (flags & ~clr) | miss;
            if (wr_en && paddr == A_IEN)
                ien <= pwdata[0];
        end
    end

    always_comb begin
        prdata = '0;
        if (psel) begin
            case (paddr)
                A_STAT:  prdata = {{(XLEN-NCLS){1'b0}}, flags};
                A_IEN:   prdata = {{(XLEN-1){1'b0}}, ien};
                A_SPC:   prdata = snap.pc;
                A_SIDX:  prdata = {{(XLEN-IDX_W){1'b0}}, snap.idx};
                A_SDAT:  prdata = snap.data;
                A_SCYC:  prdata = snap.cyc;
                default: prdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/lockstep_guard.sv
module lockstep_guard
    import lsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              a_wr_vld,
    input  logic [IDX_W-1:0]  a_wr_idx,
    input  logic [XLEN-1:0]   a_wr_data,
    input  logic              b_wr_vld,
    input  logic [IDX_W-1:0]  b_wr_idx,
    input  logic [XLEN-1:0]   b_wr_data,
    input  logic              a_rf_vld,
    input  logic [IDX_W-1:0]  a_rf_idx,
    input  logic [XLEN-1:0]   a_rf_data,
    input  logic              b_rf_vld,
    input  logic [IDX_W-1:0]  b_rf_idx,
    input  logic [XLEN-1:0]   b_rf_data,
    input  logic              a_pf_vld,
    input  logic [XLEN-1:0]   a_pf_pc,
    input  logic [XLEN-1:0]   a_pf_insn,
    input  logic              b_pf_vld,
    input  logic [XLEN-1:0]   b_pf_pc,
    input  logic [XLEN-1:0]   b_pf_insn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [XLEN-1:0]   pwdata,
    output logic [XLEN-1:0]   prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              irq
);
    logic [NCLS-1:0]  a_v, b_v;
    logic [CMP_W-1:0] a_p [NCLS];
    logic [CMP_W-1:0] b_p [NCLS];
    logic [NCLS-1:0]  miss, agree;
    logic [NCLS-1:0]  flags;
    logic             ien;
    snap_t            snap;

    always_comb begin
        a_v[CLS_WR] = a_wr_vld;
        b_v[CLS_WR] = b_wr_vld;
        a_v[CLS_RF] = a_rf_vld;
        b_v[CLS_RF] = b_rf_vld;
        a_v[CLS_PF] = a_pf_vld;
        b_v[CLS_PF] = b_pf_vld;
        a_p[CLS_WR] = pack_reg(a_wr_idx, a_wr_data);
        b_p[CLS_WR] = pack_reg(b_wr_idx, b_wr_data);
        a_p[CLS_RF] = pack_reg(a_rf_idx, a_rf_data);
        b_p[CLS_RF] = pack_reg(b_rf_idx, b_rf_data);
        a_p[CLS_PF] = pack_fetch(a_pf_pc, a_pf_insn);
        b_p[CLS_PF] = pack_fetch(b_pf_pc, b_pf_insn);
    end

    for (genvar g = 0; g < NCLS; g++) begin : g_cmp
        lsc_cmp #(.W(CMP_W)) u_cmp (
            .a_vld (a_v[g]),
            .b_vld (b_v[g]),
            .a_pay (a_p[g]),
            .b_pay (b_p[g]),
            .miss  (miss[g]),
            .agree (agree[g])
        );
    end

    lsc_snap u_snap (
        .clk     (clk),
        .rst     (rst),
        .armed   (flags == '0),
        .miss    (miss),
        .agree   (agree),
        .wr_idx  (a_wr_idx),
        .wr_data (a_wr_data),
        .pf_pc   (a_pf_pc),
        .snap    (snap)
    );

    lsc_apb u_apb (
        .clk     (clk),
        .rst     (rst),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .miss    (miss),
        .snap    (snap),
        .flags   (flags),
        .ien     (ien),
        .irq     (irq)
    );

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
endmodule

// File: rtl/lockstep_guard_chk.sv
module lockstep_guard_chk
    import lsc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              a_wr_vld,
    input logic              b_wr_vld,
    input logic              a_rf_vld,
    input logic              b_rf_vld,
    input logic              a_pf_vld,
    input logic              b_pf_vld,
    input logic [XLEN-1:0]   a_pf_insn,
    input logic [XLEN-1:0]   b_pf_insn,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [XLEN-1:0]   pwdata,
    input logic [XLEN-1:0]   prdata,
    input logic              irq,
    input logic [NCLS-1:0]   flags,
    input logic              ien,
    input snap_t             snap
);
    p_wr_onesided_r1: assert property (@(posedge clk) disable iff (rst)
        (a_wr_vld != b_wr_vld) |=> flags[CLS_WR]);

    p_rf_onesided_r2: assert property (@(posedge clk) disable iff (rst)
        (a_rf_vld != b_rf_vld) |=> flags[CLS_RF]);

    p_pf_insn_r3: assert property (@(posedge clk) disable iff (rst)
        (a_pf_vld && b_pf_vld && a_pf_insn != b_pf_insn) |=> flags[CLS_PF]);

    for (genvar i = 0; i < NCLS; i++) begin : g_sticky
        p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
            (flags[i] && !(psel && penable && pwrite && paddr == A_STAT && pwdata[i]))
            |=> flags[i]);
    end

    p_irq_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (flags == '0) |-> !irq);

    p_irq_masked_r6: assert property (@(posedge clk) disable iff (rst)
        !ien |-> !irq);

    p_snap_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (flags != '0) |=> $stable(snap));

    p_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
        (psel && paddr > A_SCYC) |-> (prdata == '0));
endmodule

bind lockstep_guard lockstep_guard_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .a_wr_vld  (a_wr_vld),
    .b_wr_vld  (b_wr_vld),
    .a_rf_vld  (a_rf_vld),
    .b_rf_vld  (b_rf_vld),
    .a_pf_vld  (a_pf_vld),
    .b_pf_vld  (b_pf_vld),
    .a_pf_insn (a_pf_insn),
    .b_pf_insn (b_pf_insn),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .prdata    (prdata),
    .irq       (irq),
    .flags     (flags),
    .ien       (ien),
    .snap      (snap)
);

// File: tb/sim_lockstep_guard.sv
`timescale 1ns/1ps
module sim_lockstep_guard;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        a_wr_vld = 0, b_wr_vld = 0, a_rf_vld = 0, b_rf_vld = 0, a_pf_vld = 0, b_pf_vld = 0;
    logic [4:0]  a_wr_idx = 0, b_wr_idx = 0, a_rf_idx = 0, b_rf_idx = 0;
    logic [31:0] a_wr_data = 0, b_wr_data = 0, a_rf_data = 0, b_rf_data = 0;
    logic [31:0] a_pf_pc = 0, b_pf_pc = 0, a_pf_insn = 0, b_pf_insn = 0;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [7:0]  paddr = 0;
    logic [31:0] pwdata = 0;
    logic [31:0] prdata;
    logic        pready, pslverr, irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] tb_cyc;
    logic [31:0] step_cyc;
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    always @(posedge clk) tb_cyc <= rst ? 32'd0 : tb_cyc + 32'd1;

    lockstep_guard u0 (
        .clk(clk), .rst(rst),
        .a_wr_vld(a_wr_vld), .a_wr_idx(a_wr_idx), .a_wr_data(a_wr_data),
        .b_wr_vld(b_wr_vld), .b_wr_idx(b_wr_idx), .b_wr_data(b_wr_data),
        .a_rf_vld(a_rf_vld), .a_rf_idx(a_rf_idx), .a_rf_data(a_rf_data),
        .b_rf_vld(b_rf_vld), .b_rf_idx(b_rf_idx), .b_rf_data(b_rf_data),
        .a_pf_vld(a_pf_vld), .a_pf_pc(a_pf_pc), .a_pf_insn(a_pf_insn),
        .b_pf_vld(b_pf_vld), .b_pf_pc(b_pf_pc), .b_pf_insn(b_pf_insn),
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
        psel = 1; pwrite = 0; paddr = a;
        @(negedge clk);
        penable = 1;
        #1;
        d = prdata;
        chk("R9 pready", {31'd0, pready}, 32'd1);
        chk("R9 pslverr", {31'd0, pslverr}, 32'd0);
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
        psel = 1; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic step_wr(input logic av, bv, input logic [4:0] ai, bi, input logic [31:0] ad, bd);
        a_wr_vld = av; b_wr_vld = bv; a_wr_idx = ai; b_wr_idx = bi; a_wr_data = ad; b_wr_data = bd;
        step_cyc = tb_cyc;
        @(negedge clk);
        a_wr_vld = 0; b_wr_vld = 0;
    endtask

    task automatic step_rf(input logic av, bv, input logic [4:0] ai, bi, input logic [31:0] ad, bd);
        a_rf_vld = av; b_rf_vld = bv; a_rf_idx = ai; b_rf_idx = bi; a_rf_data = ad; b_rf_data = bd;
        step_cyc = tb_cyc;
        @(negedge clk);
        a_rf_vld = 0; b_rf_vld = 0;
    endtask

    task automatic step_pf(input logic av, bv, input logic [31:0] ap, bp, ai, bi);
        a_pf_vld = av; b_pf_vld = bv; a_pf_pc = ap; b_pf_pc = bp; a_pf_insn = ai; b_pf_insn = bi;
        step_cyc = tb_cyc;
        @(negedge clk);
        a_pf_vld = 0; b_pf_vld = 0;
    endtask

    task automatic t_reset();
        chk("R10 irq", {31'd0, irq}, 32'd0);
        for (int k = 0; k < 6; k++) begin
            apb_read(8'(k * 4), rd);
            chk("R10 register", rd, 32'd0);
        end
    endtask

    task automatic t_agree();
        step_pf(1, 1, 32'h100, 32'h100, 32'hC0DE, 32'hC0DE);
        step_wr(1, 1, 5'd3, 5'd3, 32'hAAAA, 32'hAAAA);
        step_rf(1, 1, 5'd4, 5'd4, 32'h77, 32'h77);
        step_wr(0, 0, 5'd1, 5'd2, 32'h1, 32'h2);
        step_pf(0, 0, 32'h4, 32'h8, 32'h1, 32'h2);
        step_wr(1, 1, 5'd7, 5'd7, 32'h1234, 32'h1234);
        apb_read(8'h00, rd);
        chk("R4 agreeing and idle beats", rd, 32'd0);
    endtask

    task automatic t_first_miss();
        logic [31:0] cyc_exp;
        step_wr(1, 1, 5'd9, 5'd9, 32'h55, 32'h56);
        cyc_exp = step_cyc;
        chk("R6 irq masked", {31'd0, irq}, 32'd0);
        apb_read(8'h00, rd);
        chk("R1 data differ", rd, 32'h1);
        apb_read(8'h08, rd);  chk("R7 snap pc", rd, 32'h100);
        apb_read(8'h0C, rd);  chk("R7 snap idx", rd, 32'd7);
        apb_read(8'h10, rd);  chk("R7 snap data", rd, 32'h1234);
        apb_read(8'h14, rd);  chk("R8 snap cycle", rd, cyc_exp);
        apb_write(8'h04, 32'h1);
        #1 chk("R6 irq enabled", {31'd0, irq}, 32'd1);
        step_rf(1, 1, 5'd4, 5'd5, 32'h9, 32'h9);
        apb_read(8'h00, rd);
        chk("R2 idx differ", rd, 32'h3);
        apb_read(8'h14, rd);  chk("R7 snapshot frozen", rd, cyc_exp);
        apb_write(8'h00, 32'h1);
        apb_read(8'h00, rd);
        chk("R5 partial W1C", rd, 32'h2);
        chk("R6 irq held", {31'd0, irq}, 32'd1);
        apb_write(8'h00, 32'h0);
        apb_read(8'h00, rd);
        chk("R5 zero write keeps", rd, 32'h2);
        apb_write(8'h00, 32'h2);
        apb_read(8'h00, rd);
        chk("R5 all cleared", rd, 32'h0);
        chk("R6 irq drops", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_classes();
        logic [31:0] cyc_exp;
        step_pf(1, 1, 32'h200, 32'h200, 32'h11, 32'h11);
        step_pf(0, 1, 32'h204, 32'h204, 32'h22, 32'h22);
        cyc_exp = step_cyc;
        apb_read(8'h00, rd);
        chk("R3 one-sided prefetch", rd, 32'h4);
        apb_read(8'h08, rd);  chk("R7 recapture pc", rd, 32'h200);
        apb_read(8'h14, rd);  chk("R8 recapture cycle", rd, cyc_exp);
        apb_write(8'h00, 32'h7);
        step_pf(1, 1, 32'h208, 32'h208, 32'h33, 32'h34);
        apb_read(8'h00, rd);
        chk("R3 insn differ", rd, 32'h4);
        apb_write(8'h00, 32'h4);
        step_pf(1, 1, 32'h208, 32'h20C, 32'h33, 32'h33);
        apb_read(8'h00, rd);
        chk("R3 pc differ", rd, 32'h4);
        apb_write(8'h00, 32'h4);
        step_rf(0, 1, 5'd1, 5'd1, 32'h0, 32'h0);
        apb_read(8'h00, rd);
        chk("R2 one-sided", rd, 32'h2);
        apb_write(8'h00, 32'h2);
        step_wr(1, 0, 5'd2, 5'd2, 32'h5, 32'h5);
        apb_read(8'h00, rd);
        chk("R1 one-sided", rd, 32'h1);
        step_wr(1, 1, 5'd2, 5'd6, 32'h5, 32'h5);
        apb_read(8'h00, rd);
        chk("R1 idx differ keeps set", rd, 32'h1);
    endtask

    task automatic t_collide();
        psel = 1; pwrite = 1; paddr = 8'h00; pwdata = 32'h1;
        @(negedge clk);
        penable = 1;
        a_wr_vld = 1; b_wr_vld = 0;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
        a_wr_vld = 0;
        apb_read(8'h00, rd);
        chk("R5 set wins over clear", rd, 32'h1);
        apb_write(8'h00, 32'h1);
        apb_read(8'h00, rd);
        chk("R5 clear after collision", rd, 32'h0);
    endtask

    task automatic t_apb_map();
        logic [31:0] pc_before;
        apb_read(8'h08, pc_before);
        apb_write(8'h08, 32'hDEAD_BEEF);
        apb_read(8'h08, rd);
        chk("R9 snapshot write ignored", rd, pc_before);
        apb_read(8'h18, rd);  chk("R9 unmapped 0x18", rd, 32'd0);
        apb_read(8'h40, rd);  chk("R9 unmapped 0x40", rd, 32'd0);
        apb_read(8'h02, rd);  chk("R9 misaligned", rd, 32'd0);
        apb_read(8'h04, rd);  chk("R6 enable readback", rd, 32'd1);
    endtask

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_agree();
        t_first_miss();
        t_classes();
        t_collide();
        t_apb_map();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule